// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block is a memory-mapped general-purpose I/O controller for up to 32 pins. Software on a simple 32-bit register bus sets each pin as an input or an output, drives output levels and reads back pin levels. Any pin can also raise an interrupt. Level-sensitive triggers can be active high or active low. Edge-sensitive triggers can fire on rising edges, falling edges or both.

Incoming pad levels pass through a synchronizer before any logic sees them. Edge events are latched into a pending register until software writes ones to a clear register. Level conditions show as pending only while they hold and are enabled. All enabled pending bits are OR-ed into one interrupt line. Three per-pin configuration words together pick the trigger kind: an edge-select word, a polarity word and a both-edges word.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers are decoded on aligned byte addresses: value 0x00, direction 0x04, enable 0x08, status 0x0C, pending 0x10, clear 0x14, edge-select 0x18, polarity 0x1C, version 0x20, both-edges 0x24. Bit n of each per-pin register is pin n. Reads of the clear register, of any other offset, or of any address with nonzero low two bits return zero. Writes to status, pending, version or unused addresses change nothing.
- R2: Direction bit 1 makes a pin an input (pad_oe low). Direction bit 0 makes it an output (pad_oe high) driven from the value register on pad_out. After reset every direction bit is 1 and the value register is 0.
- R3: A value read returns the synchronized pad level for input pins and the value register bit for output pins. A pad change shows in the read after two rising clock edges.
- R4: With edge-select 0 a pin is level-triggered: polarity 1 means active high, polarity 0 means active low. The status register shows each pin's raw trigger condition.
- R5: With edge-select 1 and both-edges 0, polarity 1 triggers on rising edges and polarity 0 on falling edges of the synchronized pin.
- R6: With edge-select 1 and both-edges 1, either edge triggers, whatever the polarity bit holds.
- R7: An edge event sets the pin's pending bit, which stays set until a 1 is written to that bit position of the clear register. Positions written as 0 keep their state.
- R8: If a new edge event and a clear write hit the same pending bit in the same cycle, the bit remains set.
- R9: For a level-triggered pin, the pending bit reads as 1 exactly while its condition holds and its enable bit is 1. Nothing is latched.
- R10: The irq output is the OR of pending AND enable over all pins. The enable register resets to zero.
- R11: The version register returns the VERSION parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | NPINS | Raw pad levels |
| pad_out | output | NPINS | Output levels to the pads |
| pad_oe | output | NPINS | Output enable per pad |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted synchronizer or previous-sample register shows up as a spurious or missing status bit one cycle after the pad moves. It shows on irq one cycle later for an edge-configured pin. A pending bit that sticks or drops wrongly is seen on irq in the first cycle after the event or the clear write, as long as the pin is enabled. The bench therefore compares irq and the pad outputs against its reference model on every clock and reads the registers back after each scenario. A configuration register that is written wrongly changes the trigger kind, so the next stimulus on that pin produces an irq in the wrong cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned BUS_W = 32;
   // word indices (byte offset / 4)
   localparam int unsigned IDX_VAL  = 0;
   localparam int unsigned IDX_DIR  = 1;
   localparam int unsigned IDX_IER  = 2;
   localparam int unsigned IDX_STAT = 3;
   localparam int unsigned IDX_PEND = 4;
   localparam int unsigned IDX_CLR  = 5;
   localparam int unsigned IDX_EDGE = 6;
   localparam int unsigned IDX_POL  = 7;
   localparam int unsigned IDX_VER  = 8;
   localparam int unsigned IDX_BOTH = 9;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned N      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pad_i,
   output logic [N-1:0] sync_o,
   output logic [N-1:0] prev_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][N-1:0] chain_q;
   logic [N-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pad_i};
         prev_q  <= chain_q[LAST];
      end
   end

   assign sync_o = chain_q[LAST];
   assign prev_o = prev_q;
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sync_i,
   input  logic [N-1:0] prev_i,
   input  logic [N-1:0] edge_sel_i,
   input  logic [N-1:0] pol_i,
   input  logic [N-1:0] both_i,
   input  logic [N-1:0] ier_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o,
   output logic [N-1:0] pend_o
);
   logic [N-1:0] cond;
   logic [N-1:0] evt;
   logic [N-1:0] pend_q;
   logic [N-1:0] pend_d;

   for (genvar p = 0; p < N; p++) begin : g_pin
      logic rise, fall, edge_hit;
      assign rise     = sync_i[p] & ~prev_i[p];
      assign fall     = ~sync_i[p] & prev_i[p];
      assign edge_hit = both_i[p] ? (rise | fall) : (pol_i[p] ? rise : fall);
      assign cond[p]  = edge_sel_i[p] ? edge_hit : ~(sync_i[p] ^ pol_i[p]);
   end

   assign evt    = cond & edge_sel_i;
   assign pend_d = edge_sel_i & ((pend_q & ~clr_i) | evt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   assign stat_o = cond;
   assign pend_o = (edge_sel_i & pend_q) | (~edge_sel_i & cond & ier_i);

   // R7
   clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~evt)) |=> ((pend_q & $past(clr_i & ~evt)) == '0));
   // R8
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((pend_q & $past(evt)) == $past(evt)));
   // R5
   edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt & ~(sync_i ^ prev_i)) == '0);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N       = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter logic [31:0] VERSION = 32'h0001_0003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [N-1:0]      rb_i,
   input  logic [N-1:0]      stat_i,
   input  logic [N-1:0]      pend_i,
   output logic [N-1:0]      dir_o,
   output logic [N-1:0]      val_o,
   output logic [N-1:0]      ier_o,
   output logic [N-1:0]      edge_o,
   output logic [N-1:0]      pol_o,
   output logic [N-1:0]      both_o,
   output logic [N-1:0]      clr_o
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("gpio_regs: ADDR_W must be at least 6");
   end

   function automatic logic [BUS_W-1:0] zext(input logic [N-1:0] v);
      logic [BUS_W-1:0] r;
      r = '0;
      r[N-1:0] = v;
      return r;
   endfunction

   logic [IDX_W-1:0] idx;
   int unsigned      word;
   logic             aligned;
   logic             wr_ok;
   logic [N-1:0]     dir_q, val_q, ier_q, edge_q, pol_q, both_q;

   assign idx     = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign wr_ok   = bus_wr & aligned;
   always_comb word = 32'(idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '1;
         val_q  <= '0;
         ier_q  <= '0;
         edge_q <= '0;
         pol_q  <= '0;
         both_q <= '0;
      end else if (wr_ok) begin
         case (word)
            IDX_VAL:  val_q  <= bus_wdata[N-1:0];
            IDX_DIR:  dir_q  <= bus_wdata[N-1:0];
            IDX_IER:  ier_q  <= bus_wdata[N-1:0];
            IDX_EDGE: edge_q <= bus_wdata[N-1:0];
            IDX_POL:  pol_q  <= bus_wdata[N-1:0];
            IDX_BOTH: both_q <= bus_wdata[N-1:0];
            default: ;
         endcase
      end
   end

   assign clr_o = (wr_ok && word == IDX_CLR) ? bus_wdata[N-1:0] : '0;

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         case (word)
            IDX_VAL:  bus_rdata = zext(rb_i);
            IDX_DIR:  bus_rdata = zext(dir_q);
            IDX_IER:  bus_rdata = zext(ier_q);
            IDX_STAT: bus_rdata = zext(stat_i);
            IDX_PEND: bus_rdata = zext(pend_i);
            IDX_EDGE: bus_rdata = zext(edge_q);
            IDX_POL:  bus_rdata = zext(pol_q);
            IDX_VER:  bus_rdata = VERSION;
            IDX_BOTH: bus_rdata = zext(both_q);
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign dir_o  = dir_q;
   assign val_o  = val_q;
   assign ier_o  = ier_q;
   assign edge_o = edge_q;
   assign pol_o  = pol_q;
   assign both_o = both_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [31:0] VERSION     = 32'h0001_0003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic              irq
);
   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
      $error("gpio_irq_ctrl: NPINS must be within 1..32");
   end

   logic [NPINS-1:0] sync_w, prev_w, stat_w, pend_w;
   logic [NPINS-1:0] dir_w, val_w, ier_w, edge_w, pol_w, both_w, clr_w;
   logic [NPINS-1:0] readback;

   gpio_in_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pad_i(pad_in),
      .sync_o(sync_w), .prev_o(prev_w)
   );

   gpio_trig #(.N(NPINS)) u_trig (
      .clk(clk), .rst_n(rst_n),
      .sync_i(sync_w), .prev_i(prev_w),
      .edge_sel_i(edge_w), .pol_i(pol_w), .both_i(both_w),
      .ier_i(ier_w), .clr_i(clr_w),
      .stat_o(stat_w), .pend_o(pend_w)
   );

   assign readback = (dir_w & sync_w) | (~dir_w & val_w);

   gpio_regs #(.N(NPINS), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .rb_i(readback), .stat_i(stat_w), .pend_i(pend_w),
      .dir_o(dir_w), .val_o(val_w), .ier_o(ier_w),
      .edge_o(edge_w), .pol_o(pol_w), .both_o(both_w), .clr_o(clr_w)
   );

   assign pad_out = val_w;
   assign pad_oe  = ~dir_w;
   assign irq     = |(pend_w & ier_w);

   // R10
   no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_w == '0) |-> !irq);
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] VER = 32'h0001_0003;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   gpio_irq_ctrl #(.NPINS(32), .ADDR_W(8), .SYNC_STAGES(2), .VERSION(VER)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model state
   logic [31:0] m_dir = '1, m_val = '0, m_ier = '0, m_edge = '0, m_pol = '0, m_both = '0;
   logic [31:0] m_pend = '0, m_s1 = '0, m_s2 = '0, m_pv = '0;

   function automatic logic [31:0] m_cond();
      logic [31:0] r, f;
      r = m_s2 & ~m_pv;
      f = ~m_s2 & m_pv;
      return (m_edge & m_both & (r | f)) | (m_edge & ~m_both & m_pol & r) |
             (m_edge & ~m_both & ~m_pol & f) | (~m_edge & ~(m_s2 ^ m_pol));
   endfunction

   function automatic logic [31:0] m_pend_view();
      return (m_edge & m_pend) | (~m_edge & m_cond() & m_ier);
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      if (a[1:0] != 2'b00) return '0;
      case (a)
         8'h00: return (m_dir & m_s2) | (~m_dir & m_val);
         8'h04: return m_dir;
         8'h08: return m_ier;
         8'h0C: return m_cond();
         8'h10: return m_pend_view();
         8'h18: return m_edge;
         8'h1C: return m_pol;
         8'h20: return VER;
         8'h24: return m_both;
         default: return '0;
      endcase
   endfunction

   always @(posedge clk) begin
      logic [31:0] c, nxt, clr;
      if (!rst_n) begin
         m_dir = '1; m_val = '0; m_ier = '0; m_edge = '0; m_pol = '0; m_both = '0;
         m_pend = '0; m_s1 = '0; m_s2 = '0; m_pv = '0;
      end else begin
         c   = m_cond();
         clr = (bus_wr && bus_addr == 8'h14) ? bus_wdata : '0;
         nxt = m_edge & ((m_pend & ~clr) | (c & m_edge));
         m_pv = m_s2; m_s2 = m_s1; m_s1 = pad_in;
         if (bus_wr) begin
            case (bus_addr)
               8'h00: m_val  = bus_wdata;
               8'h04: m_dir  = bus_wdata;
               8'h08: m_ier  = bus_wdata;
               8'h18: m_edge = bus_wdata;
               8'h1C: m_pol  = bus_wdata;
               8'h24: m_both = bus_wdata;
               default: ;
            endcase
         end
         m_pend = nxt;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // every-clock comparison of irq and pad outputs
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R10 irq", {31'd0, irq}, {31'd0, |(m_pend_view() & m_ier)});
         chk("R2 pad_oe", pad_oe, ~m_dir);
         chk("R2 pad_out", pad_out, m_val);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string req, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a;
      #1;
      v = bus_rdata;
      chk(req, bus_rdata, m_read(a));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(3);
      // reset state
      rd(8'h04, "R2 dir reset", v);   chk("R2 dir reset const", v, 32'hFFFF_FFFF);
      rd(8'h08, "R10 ier reset", v);  chk("R10 ier reset const", v, 32'h0);
      rd(8'h20, "R11 version", v);    chk("R11 version const", v, VER);
      rd(8'h0C, "R4 status reset", v); chk("R4 active-low idle", v, 32'hFFFF_FFFF);
      rd(8'h10, "R9 pend reset", v);  chk("R9 pend reset const", v, 32'h0);
      // direction and value
      wr(8'h04, 32'hFFFF_0000);
      wr(8'h00, 32'h1234_A5A5);
      pad_in = 32'h00C3_0000;
      idle(3);
      rd(8'h00, "R3 readback", v); chk("R3 readback const", v, 32'h00C3_A5A5);
      // ignored writes
      wr(8'h20, 32'hDEAD_BEEF); wr(8'h0C, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h30, 32'hFFFF_FFFF); wr(8'h05, 32'h0);
      rd(8'h20, "R1 version write ignored", v); chk("R11 version kept", v, VER);
      rd(8'h30, "R1 unused reads zero", v);
      rd(8'h05, "R1 unaligned reads zero", v);
      rd(8'h14, "R1 clear reads zero", v);
      rd(8'h04, "R1 dir unchanged", v);
      rd(8'h10, "R1 pend unchanged", v);
      // level active high on pin 20
      pad_in = '0;
      wr(8'h1C, 32'h0010_0000);
      wr(8'h08, 32'h0010_0000);
      idle(3);
      rd(8'h10, "R9 level inactive", v);
      pad_in[20] = 1'b1;
      idle(3);
      rd(8'h0C, "R4 status level high", v);
      rd(8'h10, "R9 level active", v); chk("R9 level pend bit", {31'd0, v[20]}, 32'd1);
      chk("R10 irq level", {31'd0, irq}, 32'd1);
      wr(8'h14, 32'h0010_0000);
      rd(8'h10, "R9 level not cleared", v);
      pad_in[20] = 1'b0;
      idle(3);
      chk("R9 level released", {31'd0, irq}, 32'd0);
      // active-low pin 19 not enabled -> no irq
      rd(8'h0C, "R4 active-low status", v);
      // rising on 21, falling on 22, both on 23
      wr(8'h18, 32'h00E0_0000);
      wr(8'h1C, 32'h0030_0000);
      wr(8'h24, 32'h0080_0000);
      pad_in[22] = 1'b1;
      idle(4);
      wr(8'h14, 32'h00E0_0000);
      wr(8'h08, 32'h00E0_0000);
      rd(8'h10, "R7 pend clear", v); chk("R7 pend cleared", v, 32'h0);
      pad_in[21] = 1'b1;
      idle(4);
      rd(8'h10, "R5 rising", v); chk("R5 rising latched", v, 32'h0020_0000);
      pad_in[21] = 1'b0;
      idle(4);
      rd(8'h10, "R5 falling ignored on rising pin", v);
      wr(8'h14, 32'h0040_0000);
      rd(8'h10, "R7 clear other bit keeps", v); chk("R7 bit kept", v, 32'h0020_0000);
      wr(8'h14, 32'h0020_0000);
      pad_in[22] = 1'b0;
      idle(4);
      rd(8'h10, "R5 falling", v); chk("R5 falling latched", v, 32'h0040_0000);
      wr(8'h14, 32'h0040_0000);
      pad_in[23] = 1'b1;
      idle(4);
      rd(8'h10, "R6 both rise", v); chk("R6 both rise latched", v, 32'h0080_0000);
      // event coincides with clear on pin 23
      @(negedge clk); pad_in[23] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h0080_0000;
      @(negedge clk); bus_wr = 1'b0;
      rd(8'h10, "R8 event wins", v); chk("R8 event wins bit", {31'd0, v[23]}, 32'd1);
      wr(8'h14, 32'h0080_0000);
      rd(8'h10, "R7 cleared after", v); chk("R7 clear pin23", {31'd0, v[23]}, 32'd0);
      wr(8'h08, 32'h0);
      idle(2);
      chk("R10 irq off", {31'd0, irq}, 32'd0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule